// File: doc/BRIEF.md
# Posted-Write Peripheral Bus Bridge

The bridge sits between a fast processor-side request port and a slower peripheral register bus. It sorts every request by address into one of three regions: a fixed peripheral window at a constant base, a programmable peripheral window whose base comes from a configuration input, and everything else. Requests to either peripheral window become a peripheral-side transfer. The transfer stretches over one base cycle plus a global wait count plus a latency that the addressed register reports. All other requests go to an external port untouched and without delay.

The stall output tells the processor when it has to hold its request. Reads, and any access to the fixed window, hold the processor until the peripheral transfer finishes. A write to the programmable window is posted into a one-entry buffer and the processor moves on at once. That buffer must drain before any later peripheral access can start, so peripheral accesses always happen in program order.

The processor keeps its request, address, direction and data steady while the stall output is high. The request completes in the first cycle in which the request is high and the stall output is low. Read data is valid in that same cycle.

Top module: `pbb_top`

## Requirements
- R1: An address whose bits [15:12] equal 4'hF is in the fixed window. Otherwise, an address whose bits [15:12] equal bits [15:12] of `cfg_prog_base` is in the programmable window. Every other address is external. Changing `cfg_prog_base` moves the programmable window.
- R2: An external request drives `ext_req` with the address, direction and data unchanged. It never stalls, and its read data is `ext_rdata`.
- R3: `pb_sel` stays high for exactly 1 + `cfg_wait` + `pb_lat` consecutive cycles per transfer. `pb_ack` is high only in the last of them.
- R4: When the bridge is idle, a read or write to the fixed window stalls from the request cycle through the transfer, for 1 + `cfg_wait` + `pb_lat` cycles in total. It completes in the acknowledge cycle.
- R5: A read from the programmable window stalls in the same way. It returns `pb_rdata` as sampled in the acknowledge cycle.
- R6: A write to the programmable window while the bridge is idle does not stall. It completes in the cycle it is presented.
- R7: A write to the programmable window while a posted write is in flight stalls through that write's acknowledge cycle. It is accepted in the cycle after.
- R8: A read or fixed-window access issued while a posted write is pending waits for the write to drain and then runs its own transfer. Reads always see every earlier write.
- R9: The posted address, data and direction on the peripheral side stay stable from the start of a transfer until its acknowledge.
- R10: During reset and after it, `cpu_stall` and `pb_sel` are low. Reset release is synchronized to `clk`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wait | input | 3 | Extra peripheral wait cycles, 0 to 7 |
| cfg_prog_base | input | 16 | Base of the programmable peripheral window |
| cpu_req | input | 1 | Processor request valid |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 16 | Request address |
| cpu_wdata | input | 32 | Write data |
| cpu_stall | output | 1 | Processor must hold its request |
| cpu_rdata | output | 32 | Read data, valid when the request completes |
| pb_sel | output | 1 | Peripheral transfer in progress |
| pb_we | output | 1 | Peripheral transfer is a write |
| pb_addr | output | 16 | Peripheral address |
| pb_wdata | output | 32 | Peripheral write data |
| pb_rdata | input | 32 | Peripheral read data |
| pb_lat | input | 3 | Extra latency of the addressed register |
| pb_ack | output | 1 | Last cycle of the peripheral transfer |
| ext_req | output | 1 | External request |
| ext_we | output | 1 | External direction |
| ext_addr | output | 16 | External address |
| ext_wdata | output | 32 | External write data |
| ext_rdata | input | 32 | External read data |

## Verification
The bench chains accesses back to back with no gap, so posted writes are hit by a second write, by a read of the same register, and by a fixed-window access. A bridge that let a read overtake the pending write would return stale data. A bridge that freed the stall one cycle early or late would show a stall count off by one from the model. The bench repeats this with wait settings 0, 5 and 7 and varied register latencies, which catches a counter that drops the wait or latency term. It also moves the programmable base during the run and checks that the old window now goes to the external port, which a bridge that decodes a stale base would not do.

// File: rtl/pbb_pkg.sv
package pbb_pkg;
  typedef enum logic [1:0] {
    RGN_EXT  = 2'd0,
    RGN_FIX  = 2'd1,
    RGN_PROG = 2'd2
  } rgn_e;
endpackage

// File: rtl/pbb_rst_sync.sv
module pbb_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/pbb_region_dec.sv
module pbb_region_dec
  import pbb_pkg::*;
#(
  parameter int          AW        = 16,
  parameter logic [15:0] FIX_BASE  = 16'hF000,
  parameter int          FIX_BITS  = 12,
  parameter int          PROG_BITS = 12
) (
  input  logic [AW-1:0] addr,
  input  logic [AW-1:0] prog_base,
  output rgn_e          rgn
);
  logic hit_fix;
  logic hit_prog;

  assign hit_fix  = (addr[AW-1:FIX_BITS]  == FIX_BASE[AW-1:FIX_BITS]);
  assign hit_prog = (addr[AW-1:PROG_BITS] == prog_base[AW-1:PROG_BITS]);

  // fixed window wins on overlap
  always_comb begin
    if (hit_fix)       rgn = RGN_FIX;
    else if (hit_prog) rgn = RGN_PROG;
    else               rgn = RGN_EXT;
  end
endmodule

// File: rtl/pbb_wait_cnt.sv
module pbb_wait_cnt #(
  parameter int WW = 3,
  parameter int LW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          active,
  input  logic [WW-1:0] wait_cfg,
  input  logic [LW-1:0] lat,
  output logic          done
);
  localparam int CW = $clog2((1 << WW) + (1 << LW) - 1);

  logic [CW-1:0] cnt_q, cnt_d, limit;

  assign limit = CW'(wait_cfg) + CW'(lat);
  assign done  = active && (cnt_q == limit);

  always_comb begin
    if (!active || done) cnt_d = '0;
    else                 cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R3: counter never passes the programmed length
  a_r3_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (cnt_q <= limit));
  // R3: a running transfer restarts its count only after completion
  a_r3_cnt_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !done) |=> (cnt_q != '0));
endmodule

// File: rtl/pbb_xfer_ctrl.sv
module pbb_xfer_ctrl
  import pbb_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  rgn_e          rgn,
  input  logic          xfer_done,
  output logic          stall,
  output logic          active,
  output logic          xwe,
  output logic [AW-1:0] xaddr,
  output logic [DW-1:0] xdata
);
  logic          act_q, act_d;
  logic          post_q;
  logic          we_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;
  logic          periph, posts, start, own_done;

  assign periph   = req && (rgn != RGN_EXT);
  assign posts    = (rgn == RGN_PROG) && we;
  assign start    = periph && !act_q;
  assign own_done = act_q && !post_q && xfer_done;

  // blocking requests wait for their own completion; a posted write waits
  // only for a busy bus
  always_comb begin
    if (!periph)    stall = 1'b0;
    else if (act_q) stall = !own_done;
    else            stall = !posts;
  end

  always_comb begin
    if (act_q) act_d = !xfer_done;
    else       act_d = start;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) act_q <= 1'b0;
    else        act_q <= act_d;
  end

  // transfer register, doubling as the single posted-write slot
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      post_q <= 1'b0;
      we_q   <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
    end else if (start) begin
      post_q <= posts;
      we_q   <= we;
      addr_q <= addr;
      data_q <= wdata;
    end
  end

  assign active = act_q;
  assign xwe    = we_q;
  assign xaddr  = addr_q;
  assign xdata  = data_q;

  // R9: held contents until acknowledge
  a_r9_post_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && !xfer_done) |=> ($stable(addr_q) && $stable(data_q) && $stable(we_q)));
  // R5: a blocking request is only released by its own acknowledge
  a_r5_release_on_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (periph && !posts && !stall) |-> (xfer_done && act_q && !post_q));
  // R7: bus is free the cycle after a drained posted write
  a_r7_drain_frees: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && post_q && xfer_done) |=> !act_q);
  // R6: an unstalled posted write starts a transfer next cycle
  a_r6_post_starts: assert property (@(posedge clk) disable iff (!rst_n)
    (periph && posts && !stall) |=> act_q);
endmodule

// File: rtl/pbb_top.sv
module pbb_top
  import pbb_pkg::*;
#(
  parameter int          AW        = 16,
  parameter int          DW        = 32,
  parameter int          WW        = 3,
  parameter int          LW        = 3,
  parameter logic [15:0] FIX_BASE  = 16'hF000,
  parameter int          FIX_BITS  = 12,
  parameter int          PROG_BITS = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [WW-1:0] cfg_wait,
  input  logic [AW-1:0] cfg_prog_base,
  input  logic          cpu_req,
  input  logic          cpu_we,
  input  logic [AW-1:0] cpu_addr,
  input  logic [DW-1:0] cpu_wdata,
  output logic          cpu_stall,
  output logic [DW-1:0] cpu_rdata,
  output logic          pb_sel,
  output logic          pb_we,
  output logic [AW-1:0] pb_addr,
  output logic [DW-1:0] pb_wdata,
  input  logic [DW-1:0] pb_rdata,
  input  logic [LW-1:0] pb_lat,
  output logic          pb_ack,
  output logic          ext_req,
  output logic          ext_we,
  output logic [AW-1:0] ext_addr,
  output logic [DW-1:0] ext_wdata,
  input  logic [DW-1:0] ext_rdata
);
  logic rst_sync_n;
  rgn_e rgn;
  logic xfer_done;
  logic active;

  pbb_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  pbb_region_dec #(
    .AW(AW), .FIX_BASE(FIX_BASE), .FIX_BITS(FIX_BITS), .PROG_BITS(PROG_BITS)
  ) u_dec (
    .addr      (cpu_addr),
    .prog_base (cfg_prog_base),
    .rgn       (rgn)
  );

  pbb_wait_cnt #(.WW(WW), .LW(LW)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .active   (active),
    .wait_cfg (cfg_wait),
    .lat      (pb_lat),
    .done     (xfer_done)
  );

  pbb_xfer_ctrl #(.AW(AW), .DW(DW)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .req       (cpu_req),
    .we        (cpu_we),
    .addr      (cpu_addr),
    .wdata     (cpu_wdata),
    .rgn       (rgn),
    .xfer_done (xfer_done),
    .stall     (cpu_stall),
    .active    (active),
    .xwe       (pb_we),
    .xaddr     (pb_addr),
    .xdata     (pb_wdata)
  );

  assign pb_sel    = active;
  assign pb_ack    = xfer_done;
  assign ext_req   = cpu_req && (rgn == RGN_EXT);
  assign ext_we    = cpu_we;
  assign ext_addr  = cpu_addr;
  assign ext_wdata = cpu_wdata;
  assign cpu_rdata = (rgn == RGN_EXT) ? ext_rdata : pb_rdata;

  // R3: select is held until acknowledge
  a_r3_sel_hold: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (pb_sel && !pb_ack) |=> pb_sel);
  // R3: acknowledge only inside a transfer
  a_r3_ack_in_sel: assert property (@(posedge clk) disable iff (!rst_sync_n)
    pb_ack |-> pb_sel);
  // R2: external requests are never stalled
  a_r2_ext_no_stall: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ext_req |-> !cpu_stall);
  // R10: no transfer right after reset release
  a_r10_idle_after_reset: assert property (@(posedge clk)
    !rst_sync_n |=> !pb_sel);
endmodule

// File: tb/pbb_top_bench.sv
module pbb_top_bench;
  logic        clk;
  logic        rst_n;
  logic [2:0]  cfg_wait;
  logic [15:0] cfg_prog_base;
  logic        cpu_req, cpu_we;
  logic [15:0] cpu_addr;
  logic [31:0] cpu_wdata;
  logic        cpu_stall;
  logic [31:0] cpu_rdata;
  logic        pb_sel, pb_we, pb_ack;
  logic [15:0] pb_addr;
  logic [31:0] pb_wdata, pb_rdata;
  logic [2:0]  pb_lat;
  logic        ext_req, ext_we;
  logic [15:0] ext_addr;
  logic [31:0] ext_wdata, ext_rdata;

  int checks = 0;
  int errors = 0;
  int pend   = 0;
  int cycles = 0;
  logic [31:0] mem   [64];
  logic [31:0] refm  [64];

  pbb_top u_pbb_top (.*);

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [5:0] idx(input logic [15:0] a);
    return {a[15:12] == 4'hF, a[6:2]};
  endfunction
  function automatic logic [31:0] seed_val(input int i);
    return 32'hA500_0000 + 32'(i * 7);
  endfunction

  // peripheral register model
  assign pb_lat    = pb_addr[4:2];
  assign pb_rdata  = mem[idx(pb_addr)];
  assign ext_rdata = {16'hE0E0, ext_addr};

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (!rst_n) begin
      for (int i = 0; i < 64; i++) mem[i] <= seed_val(i);
    end else if (pb_ack && pb_we) begin
      mem[idx(pb_addr)] <= pb_wdata;
    end
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #2_000_000;
    checks++;
    errors++;
    $display("FAIL watchdog actual=%0d expected=done", cycles);
    finish_run();
  end

  // R3: transfer length monitor
  initial begin
    int len = 0;
    forever begin
      @(negedge clk);
      #2;
      if (pb_sel) len++;
      if (pb_ack) begin
        check(len == 1 + int'(cfg_wait) + int'(pb_addr[4:2]), "R3 transfer length",
              len, 1 + int'(cfg_wait) + int'(pb_addr[4:2]));
        len = 0;
      end
    end
  end

  task automatic access(input logic we, input logic [15:0] a, input logic [31:0] d,
                        output int stalls, output logic [31:0] rd, output logic saw_ext);
    cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
    stalls = 0;
    #1;
    saw_ext = ext_req;
    while (cpu_stall) begin
      stalls++;
      @(negedge clk);
      #1;
    end
    rd = cpu_rdata;
    @(negedge clk);
    cpu_req = 1'b0;
  endtask

  task automatic do_op(input logic we, input logic [15:0] a, input logic [31:0] d, input int gap);
    bit fix, prog, ext, posted;
    int n, exp_st, st;
    logic [31:0] rd;
    logic sx;
    fix    = (a[15:12] == 4'hF);
    prog   = !fix && (a[15:12] == cfg_prog_base[15:12]);
    ext    = !fix && !prog;
    posted = prog && we;
    n      = int'(cfg_wait) + int'(a[4:2]);
    if (ext)         exp_st = 0;
    else if (posted) exp_st = pend;
    else             exp_st = pend + 1 + n;
    access(we, a, d, st, rd, sx);
    if (ext) begin
      check(st == 0, "R2 external no stall", st, 0);
      check(sx == 1'b1, "R1 external decode", sx, 1);
      if (!we) check(rd == {16'hE0E0, a}, "R2 external read data", rd, {16'hE0E0, a});
    end else begin
      check(sx == 1'b0, "R1 peripheral decode", sx, 0);
      if (posted && pend == 0)  check(st == exp_st, "R6 posted write", st, exp_st);
      else if (posted)          check(st == exp_st, "R7 write behind posted", st, exp_st);
      else if (pend > 0)        check(st == exp_st, "R8 access behind posted", st, exp_st);
      else if (fix)             check(st == exp_st, "R4 fixed access stall", st, exp_st);
      else                      check(st == exp_st, "R5 prog read stall", st, exp_st);
      if (!we) check(rd == refm[idx(a)], "R5/R8 read data order", rd, refm[idx(a)]);
      if (we) refm[idx(a)] = d;
    end
    if (posted)   pend = 1 + n - gap;
    else if (ext) pend = pend - 1 - gap;
    else          pend = 0 - gap;
    if (pend < 0) pend = 0;
    repeat (gap) @(negedge clk);
  endtask

  function automatic logic [15:0] pick_addr(input int r, input int off);
    logic [15:0] o;
    o = 16'(off) & 16'h007C;
    case (r)
      0:       return 16'hF000 | o;
      1:       return cfg_prog_base | o;
      default: return 16'h2000 | o;
    endcase
  endfunction

  task automatic random_phase(input int count);
    for (int k = 0; k < count; k++) begin
      int r;
      r = int'($urandom_range(0, 2));
      do_op(1'($urandom_range(0, 1)), pick_addr(r, int'($urandom_range(0, 127))),
            $urandom, int'($urandom_range(0, 3)));
    end
  endtask

  initial begin
    void'($urandom(32'h5EED_0042));
    for (int i = 0; i < 64; i++) refm[i] = seed_val(i);
    rst_n = 1'b0; cpu_req = 1'b0; cpu_we = 1'b0; cpu_addr = '0; cpu_wdata = '0;
    cfg_wait = 3'd2; cfg_prog_base = 16'h4000;
    repeat (3) @(negedge clk);
    check(cpu_stall == 1'b0 && pb_sel == 1'b0, "R10 reset outputs", {cpu_stall, pb_sel}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(cpu_stall == 1'b0 && pb_sel == 1'b0, "R10 after release", {cpu_stall, pb_sel}, 0);

    // directed corner cases, back to back
    do_op(1'b0, 16'hF008, 32'h0, 0);          // R4 fixed read, idle
    do_op(1'b1, 16'h4010, 32'h1111_2222, 0);  // R6 posted
    do_op(1'b1, 16'h4014, 32'h3333_4444, 0);  // R7 behind posted
    do_op(1'b0, 16'h4010, 32'h0, 0);          // R8 read sees first write
    do_op(1'b1, 16'h4018, 32'h5555_6666, 0);  // R6 posted
    do_op(1'b1, 16'hF018, 32'h7777_8888, 0);  // R8 fixed write behind posted
    do_op(1'b0, 16'h4018, 32'h0, 0);          // R5 read back
    do_op(1'b0, 16'h2044, 32'h0, 2);          // R2 external

    cfg_wait = 3'd0;
    random_phase(150);
    repeat (20) @(negedge clk); pend = 0;
    cfg_wait = 3'd5;
    random_phase(80);
    repeat (20) @(negedge clk); pend = 0;
    cfg_wait = 3'd7;
    cfg_prog_base = 16'h8000;
    do_op(1'b0, 16'h4010, 32'h0, 0);          // R1 old window is external
    do_op(1'b0, 16'h8010, 32'h0, 0);          // R1 new window is peripheral
    random_phase(70);
    repeat (30) @(negedge clk);
    finish_run();
  end
endmodule